// File: doc/BRIEF.md
# Pipeline Forwarding and Stall Unit

This block makes the data-hazard decisions for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) whose branches are resolved in decode. It reads register indices, write enables and load flags from the three pipeline registers behind decode. From them it produces four kinds of control: the select codes for the two execute-stage operand multiplexers, the select bits for the two decode-stage branch-comparator multiplexers, a stall that freezes the program counter and the fetch/decode register while a bubble enters decode/execute, and a flush of the fetch/decode register for a taken branch.

The unit is purely combinational and sits between the pipeline registers and the datapath multiplexers. ALU results are routed from the execute/memory register back to the start of execute, so the operand read in decode is simply replaced. The branch comparator gets its own path from the execute/memory register. A value in writeback reaches decode through the register file's same-cycle write-through, so no separate writeback-to-decode path exists. The decision pins are plain level signals. They carry no handshake, because the pipeline registers are advanced by the same clock on every cycle that the stall signal is low.

Top module: `hz_fwd_unit`

## Requirements
- R1: Each execute operand select is 2 bits: 2'b00 takes the register-file value, 2'b10 takes the execute/memory result, and 2'b01 takes the memory/writeback result. The code 2'b11 is never produced.
- R2: When the execute/memory and memory/writeback destinations both match an operand source, the select is 2'b10.
- R3: A match on register index 0 never causes forwarding, a branch select or a stall.
- R4: A stage whose write enable is low never causes forwarding, a branch select or a stall, whatever its destination index.
- R5: A branch select bit is 1 exactly when the memory-stage instruction writes, is not a load, and has a non-zero destination equal to that comparator source. A writeback-stage match alone leaves it 0.
- R6: A load in execute whose non-zero destination equals either decode source raises pc_hold, ifid_hold and idex_bubble together.
- R7: A branch in decode whose source equals the non-zero destination of a writing non-load in execute stalls (all three stall outputs high).
- R8: A branch in decode whose source equals the non-zero destination of a load in memory stalls. Together with R6, a branch that depends on a load stalls twice: once with the load in execute and once with it in memory.
- R9: ifid_flush is high exactly when decode holds a branch whose condition is taken and no stall is raised in that cycle.
- R10: A non-branch in decode is not stalled by a non-load producer in execute or by a load in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_IDX_W | First source index of the instruction in decode |
| id_src_b | input | REG_IDX_W | Second source index of the instruction in decode |
| id_is_branch | input | 1 | Decode holds a conditional branch |
| id_br_taken | input | 1 | Branch comparator result for the decode instruction |
| ex_src_a | input | REG_IDX_W | First source index held in decode/execute |
| ex_src_b | input | REG_IDX_W | Second source index held in decode/execute |
| ex_dst | input | REG_IDX_W | Destination index held in decode/execute |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_IDX_W | Destination index held in execute/memory |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | REG_IDX_W | Destination index held in memory/writeback |
| wb_wen | input | 1 | Writeback instruction writes a register |
| ex_sel_a | output | 2 | Execute operand A select (R1 encoding) |
| ex_sel_b | output | 2 | Execute operand B select (R1 encoding) |
| br_sel_a | output | 1 | Comparator source A takes the execute/memory result |
| br_sel_b | output | 1 | Comparator source B takes the execute/memory result |
| pc_hold | output | 1 | Freeze the program counter |
| ifid_hold | output | 1 | Freeze the fetch/decode register |
| idex_bubble | output | 1 | Load an all-zero control bubble into decode/execute |
| ifid_flush | output | 1 | Clear the fetch/decode register at the next edge |

## Verification
The bench sweeps every combination of indices and flags over a 4-register configuration. This reaches the points where a wrong design goes astray. Reversing the priority would send a stale writeback value into execute. Forwarding from register 0 or from a non-writing stage would corrupt operands or stall for nothing. Dropping the load-in-memory term would let a branch compare before its load data exists. Flushing while stalled would throw away the branch that is being held. Directed sequences replay a set-less-than followed by a branch-if-nonzero, and a load followed by a branch, to confirm the one-cycle and two-cycle stalls.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FSEL_RF  = 2'b00,
    FSEL_WB  = 2'b01,
    FSEL_MEM = 2'b10
  } fsel_e;
endpackage

// File: rtl/hz_ex_fwd.sv
// Execute-stage operand select for one operand; memory stage wins.
module hz_ex_fwd #(
  parameter int REG_IDX_W = 5
) (
  input  logic [REG_IDX_W-1:0] src,
  input  logic [REG_IDX_W-1:0] mem_dst,
  input  logic                 mem_wen,
  input  logic [REG_IDX_W-1:0] wb_dst,
  input  logic                 wb_wen,
  output logic [1:0]           sel
);
  import hz_pkg::*;
  localparam logic [REG_IDX_W-1:0] ZERO_IDX = '0;

  logic mem_hit, wb_hit;
  assign mem_hit = mem_wen && (mem_dst != ZERO_IDX) && (mem_dst == src);
  assign wb_hit  = wb_wen  && (wb_dst  != ZERO_IDX) && (wb_dst  == src);

  always_comb begin
    if (mem_hit)     sel = FSEL_MEM;
    else if (wb_hit) sel = FSEL_WB;
    else             sel = FSEL_RF;
  end
endmodule

// File: rtl/hz_br_fwd.sv
// Branch comparator select: only a non-load result held after execute.
module hz_br_fwd #(
  parameter int REG_IDX_W = 5
) (
  input  logic [REG_IDX_W-1:0] src,
  input  logic [REG_IDX_W-1:0] mem_dst,
  input  logic                 mem_wen,
  input  logic                 mem_is_load,
  output logic                 hit
);
  localparam logic [REG_IDX_W-1:0] ZERO_IDX = '0;
  assign hit = mem_wen && !mem_is_load && (mem_dst != ZERO_IDX) && (mem_dst == src);
endmodule

// File: rtl/hz_stall.sv
// Stall decision over all decode sources.
module hz_stall #(
  parameter int REG_IDX_W = 5,
  parameter int NUM_SRC   = 2
) (
  input  logic [NUM_SRC-1:0][REG_IDX_W-1:0] id_src,
  input  logic                              id_is_branch,
  input  logic [REG_IDX_W-1:0]              ex_dst,
  input  logic                              ex_wen,
  input  logic                              ex_is_load,
  input  logic [REG_IDX_W-1:0]              mem_dst,
  input  logic                              mem_wen,
  input  logic                              mem_is_load,
  output logic                              stall
);
  localparam logic [REG_IDX_W-1:0] ZERO_IDX = '0;

  logic ex_live, mem_load_live;
  logic [NUM_SRC-1:0] ex_match, mem_match;

  assign ex_live       = ex_wen && (ex_dst != ZERO_IDX);
  assign mem_load_live = mem_wen && mem_is_load && (mem_dst != ZERO_IDX);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign ex_match[s]  = ex_live       && (id_src[s] == ex_dst);
    assign mem_match[s] = mem_load_live && (id_src[s] == mem_dst);
  end

  logic load_use, br_on_ex, br_on_mem_load;
  assign load_use       = ex_is_load && (|ex_match);
  assign br_on_ex       = id_is_branch && !ex_is_load && (|ex_match);
  assign br_on_mem_load = id_is_branch && (|mem_match);
  assign stall          = load_use || br_on_ex || br_on_mem_load;
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit #(
  parameter int REG_IDX_W = 5
) (
  input  logic [REG_IDX_W-1:0] id_src_a,
  input  logic [REG_IDX_W-1:0] id_src_b,
  input  logic                 id_is_branch,
  input  logic                 id_br_taken,
  input  logic [REG_IDX_W-1:0] ex_src_a,
  input  logic [REG_IDX_W-1:0] ex_src_b,
  input  logic [REG_IDX_W-1:0] ex_dst,
  input  logic                 ex_wen,
  input  logic                 ex_is_load,
  input  logic [REG_IDX_W-1:0] mem_dst,
  input  logic                 mem_wen,
  input  logic                 mem_is_load,
  input  logic [REG_IDX_W-1:0] wb_dst,
  input  logic                 wb_wen,
  output logic [1:0]           ex_sel_a,
  output logic [1:0]           ex_sel_b,
  output logic                 br_sel_a,
  output logic                 br_sel_b,
  output logic                 pc_hold,
  output logic                 ifid_hold,
  output logic                 idex_bubble,
  output logic                 ifid_flush
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_IDX_W-1:0] id_src_v, ex_src_v;
  logic [NUM_SRC-1:0][1:0]           ex_sel_v;
  logic [NUM_SRC-1:0]                br_sel_v;
  logic                              stall;

  assign id_src_v = {id_src_b, id_src_a};
  assign ex_src_v = {ex_src_b, ex_src_a};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_op
    hz_ex_fwd #(.REG_IDX_W(REG_IDX_W)) ex_fwd_i (
      .src     (ex_src_v[s]),
      .mem_dst (mem_dst),
      .mem_wen (mem_wen),
      .wb_dst  (wb_dst),
      .wb_wen  (wb_wen),
      .sel     (ex_sel_v[s])
    );
    hz_br_fwd #(.REG_IDX_W(REG_IDX_W)) br_fwd_i (
      .src         (id_src_v[s]),
      .mem_dst     (mem_dst),
      .mem_wen     (mem_wen),
      .mem_is_load (mem_is_load),
      .hit         (br_sel_v[s])
    );
  end

  hz_stall #(.REG_IDX_W(REG_IDX_W), .NUM_SRC(NUM_SRC)) stall_i (
    .id_src       (id_src_v),
    .id_is_branch (id_is_branch),
    .ex_dst       (ex_dst),
    .ex_wen       (ex_wen),
    .ex_is_load   (ex_is_load),
    .mem_dst      (mem_dst),
    .mem_wen      (mem_wen),
    .mem_is_load  (mem_is_load),
    .stall        (stall)
  );

  assign ex_sel_a    = ex_sel_v[0];
  assign ex_sel_b    = ex_sel_v[1];
  assign br_sel_a    = br_sel_v[0];
  assign br_sel_b    = br_sel_v[1];
  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;
  assign ifid_flush  = id_is_branch && id_br_taken && !stall;
endmodule

// File: rtl/hz_fwd_unit_chk.sv
module hz_fwd_unit_chk #(
  parameter int REG_IDX_W = 5
) (
  input logic [REG_IDX_W-1:0] id_src_a,
  input logic [REG_IDX_W-1:0] id_src_b,
  input logic                 id_is_branch,
  input logic                 id_br_taken,
  input logic [REG_IDX_W-1:0] ex_src_a,
  input logic [REG_IDX_W-1:0] ex_src_b,
  input logic [REG_IDX_W-1:0] ex_dst,
  input logic                 ex_wen,
  input logic                 ex_is_load,
  input logic [REG_IDX_W-1:0] mem_dst,
  input logic                 mem_wen,
  input logic                 mem_is_load,
  input logic [REG_IDX_W-1:0] wb_dst,
  input logic                 wb_wen,
  input logic [1:0]           ex_sel_a,
  input logic [1:0]           ex_sel_b,
  input logic                 br_sel_a,
  input logic                 br_sel_b,
  input logic                 pc_hold,
  input logic                 ifid_hold,
  input logic                 idex_bubble,
  input logic                 ifid_flush
);
  localparam logic [REG_IDX_W-1:0] ZERO_IDX = '0;

  always_comb begin
    a_r1_sel_legal: assert (ex_sel_a != 2'b11 && ex_sel_b != 2'b11);
    if (ex_src_a == ZERO_IDX)
      a_r3_zero_no_fwd: assert (ex_sel_a == 2'b00);
    if (!mem_wen && !wb_wen)
      a_r4_no_writer_no_fwd: assert (ex_sel_a == 2'b00 && ex_sel_b == 2'b00);
    if (br_sel_a || br_sel_b)
      a_r5_br_src_mem: assert (mem_wen && !mem_is_load);
    a_r6_stall_coherent: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble);
    if (!ex_wen && !mem_wen)
      a_r4_no_writer_no_stall: assert (!pc_hold);
    a_r9_flush_vs_stall: assert (!(ifid_flush && pc_hold));
    if (ifid_flush)
      a_r9_flush_needs_branch: assert (id_is_branch && id_br_taken);
  end
endmodule

bind hz_fwd_unit hz_fwd_unit_chk #(.REG_IDX_W(REG_IDX_W)) chk_i (.*);

// File: tb/hz_fwd_unit_tb.sv
module hz_fwd_unit_tb_top;
  localparam int IW = 2;
  localparam int NREG = 1 << IW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [IW-1:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst;
  logic id_is_branch, id_br_taken, ex_wen, ex_is_load, mem_wen, mem_is_load, wb_wen;
  logic [1:0] ex_sel_a, ex_sel_b;
  logic br_sel_a, br_sel_b, pc_hold, ifid_hold, idex_bubble, ifid_flush;

  hz_fwd_unit #(.REG_IDX_W(IW)) dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_sel(int src, int md, int mw, int wd, int ww);
    if (mw != 0 && md != 0 && md == src) return 2;
    if (ww != 0 && wd != 0 && wd == src) return 1;
    return 0;
  endfunction

  function automatic int ref_br(int src, int md, int mw, int ml);
    return (mw != 0 && ml == 0 && md != 0 && md == src) ? 1 : 0;
  endfunction

  function automatic int ref_stall(int a, int b, int br, int ed, int ew, int el,
                                   int md, int mw, int ml);
    int exm, mm;
    exm = (ew != 0 && ed != 0 && (ed == a || ed == b)) ? 1 : 0;
    mm  = (mw != 0 && ml != 0 && md != 0 && (md == a || md == b)) ? 1 : 0;
    if (exm != 0 && el != 0) return 1;          // R6
    if (br != 0 && exm != 0 && el == 0) return 1; // R7
    if (br != 0 && mm != 0) return 1;           // R8
    return 0;
  endfunction

  task automatic idle();
    id_src_a = '0; id_src_b = '0; id_is_branch = 0; id_br_taken = 0;
    ex_src_a = '0; ex_src_b = '0; ex_dst = '0; ex_wen = 0; ex_is_load = 0;
    mem_dst = '0; mem_wen = 0; mem_is_load = 0; wb_dst = '0; wb_wen = 0;
  endtask

  task automatic check_stall(string req, int exp);
    chk(req, int'(pc_hold), exp);
    chk(req, int'(ifid_hold), exp);
    chk(req, int'(idex_bubble), exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (2) @(posedge clk);
    @(negedge clk);
    // quiet pipeline: nothing forwarded, held or flushed (R1, R4)
    chk("R1 idle sel_a", int'(ex_sel_a), 0);
    chk("R1 idle sel_b", int'(ex_sel_b), 0);
    chk("R5 idle br", int'(br_sel_a | br_sel_b), 0);
    check_stall("R4 idle stall", 0);
    chk("R9 idle flush", int'(ifid_flush), 0);

    // Sweep A: execute operand selects (R1 R2 R3 R4)
    for (int v = 0; v < (1 << (4*IW + 3)); v++) begin
      @(posedge clk); #1;
      idle();
      ex_src_a = IW'(v);
      ex_src_b = IW'(v >> IW);
      mem_dst  = IW'(v >> (2*IW));
      wb_dst   = IW'(v >> (3*IW));
      mem_wen     = v[4*IW];
      wb_wen      = v[4*IW+1];
      mem_is_load = v[4*IW+2];
      @(negedge clk);
      chk("R1/R2/R3/R4 ex_sel_a", int'(ex_sel_a),
          ref_sel(int'(ex_src_a), int'(mem_dst), int'(mem_wen), int'(wb_dst), int'(wb_wen)));
      chk("R1/R2/R3/R4 ex_sel_b", int'(ex_sel_b),
          ref_sel(int'(ex_src_b), int'(mem_dst), int'(mem_wen), int'(wb_dst), int'(wb_wen)));
    end

    // Sweep B: branch selects, stalls, flush (R3-R10)
    for (int v = 0; v < (1 << (4*IW + 7)); v++) begin
      @(posedge clk); #1;
      idle();
      id_src_a = IW'(v);
      id_src_b = IW'(v >> IW);
      ex_dst   = IW'(v >> (2*IW));
      mem_dst  = IW'(v >> (3*IW));
      ex_wen       = v[4*IW];
      ex_is_load   = v[4*IW+1];
      mem_wen      = v[4*IW+2];
      mem_is_load  = v[4*IW+3];
      id_is_branch = v[4*IW+4];
      id_br_taken  = v[4*IW+5];
      wb_wen       = v[4*IW+6];
      wb_dst       = id_src_a; // writeback match must not drive branch select (R5)
      @(negedge clk);
      begin
        int s;
        s = ref_stall(int'(id_src_a), int'(id_src_b), int'(id_is_branch), int'(ex_dst),
                      int'(ex_wen), int'(ex_is_load), int'(mem_dst), int'(mem_wen),
                      int'(mem_is_load));
        check_stall("R6/R7/R8/R10 stall", s);
        chk("R9 flush", int'(ifid_flush), (id_is_branch && id_br_taken && s == 0) ? 1 : 0);
        chk("R5 br_sel_a", int'(br_sel_a),
            ref_br(int'(id_src_a), int'(mem_dst), int'(mem_wen), int'(mem_is_load)));
        chk("R5 br_sel_b", int'(br_sel_b),
            ref_br(int'(id_src_b), int'(mem_dst), int'(mem_wen), int'(mem_is_load)));
      end
    end

    // Directed: set-less-than into r1 then branch-if-nonzero on r1 (R7, R5)
    @(posedge clk); #1;
    idle();
    id_is_branch = 1; id_br_taken = 1; id_src_a = IW'(1);
    ex_dst = IW'(1); ex_wen = 1;
    @(negedge clk);
    check_stall("R7 slt->branch cycle1", 1);
    chk("R9 held branch no flush", int'(ifid_flush), 0);
    @(posedge clk); #1;
    ex_dst = '0; ex_wen = 0; mem_dst = IW'(1); mem_wen = 1;
    @(negedge clk);
    check_stall("R7 slt->branch cycle2", 0);
    chk("R5 slt->branch fwd", int'(br_sel_a), 1);
    chk("R9 slt->branch flush", int'(ifid_flush), 1);

    // Directed: load r2 then branch on r2 stalls twice (R6, R8)
    @(posedge clk); #1;
    idle();
    id_is_branch = 1; id_src_b = IW'(2);
    ex_dst = IW'(2); ex_wen = 1; ex_is_load = 1;
    @(negedge clk);
    check_stall("R6 load->branch stall1", 1);
    @(posedge clk); #1;
    ex_dst = '0; ex_wen = 0; ex_is_load = 0;
    mem_dst = IW'(2); mem_wen = 1; mem_is_load = 1;
    @(negedge clk);
    check_stall("R8 load->branch stall2", 1);
    chk("R5 no br fwd from load", int'(br_sel_b), 0);
    @(posedge clk); #1;
    mem_dst = '0; mem_wen = 0; mem_is_load = 0; wb_dst = IW'(2); wb_wen = 1;
    @(negedge clk);
    check_stall("R8 load->branch released", 0);
    chk("R5 wb reaches via regfile", int'(br_sel_b), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule